// File: doc/BRIEF.md
# Parallel Peripheral Interface Adapter

This block gives a processor two 8-bit parallel ports, A and B, reached through four addresses on a simple synchronous register bus. Each port owns a data register, a direction register and a six-bit control register. Every port also has two handshake lines. Line 1 is always an input. Line 2 is either an input or a driven output. A control bit chooses whether the port's shared address reaches the data register or the direction register.

Edges on the handshake inputs set per-port flags that can raise an interrupt. Accessing a port's data register has side effects. A data read clears that port's flags. A data read on port A, or a data write on port B, can also fire a strobe on line 2. Line 2 can instead be driven to a fixed level by software. All inputs are treated as synchronous to `clk`. Each cycle with `rd` or `wr` high counts as one access.

Top module: `pio_adapter`

## Requirements
- R1: `sel` value 0 addresses port A, 1 addresses control A, 2 addresses port B and 3 addresses control B. For a port address, control bit 2 set to 1 selects the data register, and 0 selects the direction register.
- R2: A data read returns, bit by bit, the output register where the direction bit is 1 and the input pin where it is 0.
- R3: Each port's output pins equal its output register ANDed with its direction register. They change only in the cycle after a write.
- R4: Reading or writing a direction register leaves the interrupt flags and line 2 unchanged.
- R5: A control write stores only bits 5..0. A control read returns the line-1 flag in bit 7 and the line-2 flag in bit 6, and both flags are read-only.
- R6: An edge on line 1 sets the bit-7 flag. Control bit 1 chooses the active edge: 1 for rising, 0 for falling.
- R7: With control bit 5 at 0, line 2 is an input. Its edge sets the bit-6 flag, and control bit 4 chooses the edge: 1 for rising. With bit 5 at 1, the bit-6 flag reads 0 and line-2 input transitions are ignored.
- R8: The port interrupt is high while the bit-7 flag is set with control bit 0 at 1. It is also high while the bit-6 flag is set with control bit 3 at 1 and line 2 an input.
- R9: A data read of a port clears both of that port's flags. If an active edge arrives in the same cycle, the flag it sets stays set.
- R10: With control bits 5 and 4 both 1, a control write drives line 2 to the value of written bit 3.
- R11: With bit 5 at 1 and bit 4 at 0 (strobe mode), a port A data read or a port B data write drives that port's line 2 low in the next cycle. If bit 3 is 1, line 2 returns high one cycle later.
- R12: In strobe mode with bit 3 at 0, line 2 stays low until the next active line-1 edge of the same port, which drives it high.
- R13: Reset clears all registers and flags, and drives both interrupts and both line-2 outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 2 | Register select |
| rd | input | 1 | Read access strobe |
| wr | input | 1 | Write access strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| pa_in | input | 8 | Port A input pins |
| pa_out | output | 8 | Port A driven pin values |
| ca1 | input | 1 | Port A line 1 |
| ca2_in | input | 1 | Port A line 2 input |
| ca2_out | output | 1 | Port A line 2 output value |
| ca2_oe | output | 1 | Port A line 2 output enable |
| pb_in | input | 8 | Port B input pins |
| pb_out | output | 8 | Port B driven pin values |
| cb1 | input | 1 | Port B line 1 |
| cb2_in | input | 1 | Port B line 2 input |
| cb2_out | output | 1 | Port B line 2 output value |
| cb2_oe | output | 1 | Port B line 2 output enable |
| irq_a | output | 1 | Port A interrupt |
| irq_b | output | 1 | Port B interrupt |

## Verification
The clearing effect of a port A data read and an active line-1 edge can land in the same cycle. The bench provokes this by raising `ca1` on the same clock on which it issues the data read. It then reads control A, and bit 7 must still be set: the setting edge wins over the clear. A second overlap arises in strobe mode without self-restore. There the strobe that pulls line 2 low and the later line-1 edge that restores it drive the same output, and the bench checks that line 2 goes low and then high in that order.

// File: rtl/pio_adapter.sv
module pio_adapter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    sel,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  input  logic          ca1,
  input  logic          ca2_in,
  output logic          ca2_out,
  output logic          ca2_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  input  logic          cb1,
  input  logic          cb2_in,
  output logic          cb2_out,
  output logic          cb2_oe,
  output logic          irq_a,
  output logic          irq_b
);
  logic [1:0][DW-1:0] outr, ddr, pin_in;
  logic [1:0][5:0]    ctl;
  logic [1:0] f1, f2, c2o, pend, p1, p2, l1, l2;
  logic [1:0] e1, e2, rd_dat, wr_dat, wr_ddr, wr_ctl, strobe, irq;
  logic       pi;

  assign pin_in = {pb_in, pa_in};
  assign l1     = {cb1, ca1};
  assign l2     = {cb2_in, ca2_in};

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      rd_dat[i] = rd && (sel == {i[0], 1'b0}) && ctl[i][2];
      wr_dat[i] = wr && (sel == {i[0], 1'b0}) && ctl[i][2];
      wr_ddr[i] = wr && (sel == {i[0], 1'b0}) && !ctl[i][2];
      wr_ctl[i] = wr && (sel == {i[0], 1'b1});
      e1[i] = (l1[i] ^ p1[i]) && (l1[i] == ctl[i][1]);
      e2[i] = (l2[i] ^ p2[i]) && (l2[i] == ctl[i][4]) && !ctl[i][5];
      strobe[i] = (i == 1) ? wr_dat[i] : rd_dat[i];
      irq[i] = (f1[i] && ctl[i][0]) || (f2[i] && ctl[i][3] && !ctl[i][5]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outr <= '0; ddr <= '0; ctl <= '0;
      f1 <= '0; f2 <= '0; c2o <= '0; pend <= '0; p1 <= '0; p2 <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        p1[i]   <= l1[i];
        p2[i]   <= l2[i];
        pend[i] <= 1'b0;
        if (wr_dat[i]) outr[i] <= wdata;
        if (wr_ddr[i]) ddr[i]  <= wdata;
        if (wr_ctl[i]) ctl[i]  <= wdata[5:0];
        if (e1[i])          f1[i] <= 1'b1;
        else if (rd_dat[i]) f1[i] <= 1'b0;
        if (ctl[i][5])      f2[i] <= 1'b0;
        else if (e2[i])     f2[i] <= 1'b1;
        else if (rd_dat[i]) f2[i] <= 1'b0;
        if (wr_ctl[i] && wdata[5] && wdata[4]) c2o[i] <= wdata[3];
        else if (ctl[i][5] && !ctl[i][4] && strobe[i]) begin
          c2o[i]  <= 1'b0;
          pend[i] <= ctl[i][3];
        end
        else if (pend[i]) c2o[i] <= 1'b1;
        else if (ctl[i][5] && !ctl[i][4] && !ctl[i][3] && e1[i]) c2o[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    pi = sel[1];
    if (sel[0])          rdata = DW'({f1[pi], f2[pi] & ~ctl[pi][5], ctl[pi]});
    else if (ctl[pi][2]) rdata = (outr[pi] & ddr[pi]) | (pin_in[pi] & ~ddr[pi]);
    else                 rdata = ddr[pi];
  end

  assign pa_out  = outr[0] & ddr[0];
  assign pb_out  = outr[1] & ddr[1];
  assign ca2_out = c2o[0];
  assign cb2_out = c2o[1];
  assign ca2_oe  = ctl[0][5];
  assign cb2_oe  = ctl[1][5];
  assign irq_a   = irq[0];
  assign irq_b   = irq[1];

  assert_pins_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(pa_out) && $stable(pb_out)));

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dat[0] && !e1[0] && !e2[0]) |=> (!f1[0] && !f2[0] && !irq_a));

  assert_manual_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == 2'd1 && wdata[5] && wdata[4]) |=> (ca2_out == $past(wdata[3])));

  assert_self_restore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cb2_out) && cb2_oe && !ctl[1][4] && ctl[1][3] && !wr) |=> cb2_out);

  assert_out_mode_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[1][5] |=> !f2[1]);
endmodule

// File: tb/pio_adapter_bench.sv
module pio_adapter_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] sel = '0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0, rdata, pa_in = 8'h3C, pb_in = 8'h00, pa_out, pb_out;
  logic       ca1 = 0, ca2_in = 0, cb1 = 0, cb2_in = 0;
  logic       ca2_out, ca2_oe, cb2_out, cb2_oe, irq_a, irq_b;
  int checks = 0, failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  pio_adapter u_pio_adapter (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .wr(wr), .wdata(wdata),
    .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .ca1(ca1), .ca2_in(ca2_in),
    .ca2_out(ca2_out), .ca2_oe(ca2_oe), .pb_in(pb_in), .pb_out(pb_out),
    .cb1(cb1), .cb2_in(cb2_in), .cb2_out(cb2_out), .cb2_oe(cb2_oe),
    .irq_a(irq_a), .irq_b(irq_b));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(logic [1:0] s, logic [7:0] d);
    @(negedge clk); sel = s; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(logic [1:0] s, logic [7:0] e, string tag);
    @(negedge clk); sel = s; rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic tick(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk); #1;
      if (rd) begin
        if (exp_q.size() == 0) chk("scoreboard underflow", 8'h00, 8'h01);
        else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1'b1; tick(1);
    rreg(2'd0, 8'h00, "R13 direction A after reset");
    rreg(2'd1, 8'h00, "R13 control A after reset");
    chk("R13 irq/line2 after reset", {irq_a, irq_b, ca2_out, cb2_out}, 8'h00);
    wreg(2'd0, 8'hF0);
    rreg(2'd0, 8'hF0, "R1 direction A via address 0");
    chk("R3 pins with output reg zero", pa_out, 8'h00);
    wreg(2'd1, 8'h04);
    wreg(2'd0, 8'hA5);
    chk("R3 pins equal out AND dir", pa_out, 8'hA0);
    rreg(2'd0, 8'hAC, "R2 merged data read");
    wreg(2'd1, 8'hC4);
    rreg(2'd1, 8'h04, "R5 bits 7..6 not writable");
    wreg(2'd1, 8'h07);
    ca1 = 1'b1; tick(1);
    rreg(2'd1, 8'h87, "R6 rising edge sets flag");
    chk("R8 irq_a on enabled flag", irq_a, 1'b1);
    rreg(2'd0, 8'hAC, "R9 clearing data read");
    rreg(2'd1, 8'h07, "R9 flag cleared");
    chk("R9 irq_a cleared", irq_a, 1'b0);
    ca1 = 1'b0; tick(2);
    rreg(2'd1, 8'h07, "R6 falling edge inactive");
    wreg(2'd1, 8'h03);
    ca1 = 1'b1; tick(1);
    rreg(2'd0, 8'hF0, "R4 direction read");
    rreg(2'd1, 8'h83, "R4 flag kept after direction read");
    wreg(2'd2, 8'h0F);
    chk("R4 line2 untouched by direction write", ca2_out, 1'b0);
    wreg(2'd1, 8'h07);
    rreg(2'd0, 8'hAC, "R9 clear before overlap");
    ca1 = 1'b0; tick(2);
    @(negedge clk); sel = 2'd0; rd = 1'b1; ca1 = 1'b1;
    exp_q.push_back(8'hAC); tag_q.push_back("R9 overlap data read");
    @(negedge clk); rd = 1'b0;
    rreg(2'd1, 8'h87, "R9 edge wins over clear");
    rreg(2'd0, 8'hAC, "R9 final clear");
    wreg(2'd3, 8'h1C);
    cb2_in = 1'b1; tick(1);
    rreg(2'd3, 8'h5C, "R7 line2 rising sets bit6");
    chk("R8 irq_b on line2 flag", irq_b, 1'b1);
    wreg(2'd3, 8'h3C);
    chk("R10 manual high", cb2_out, 1'b1);
    rreg(2'd3, 8'h3C, "R7 bit6 reads 0 in output mode");
    chk("R7 irq_b off in output mode", irq_b, 1'b0);
    cb2_in = 1'b0; tick(1); cb2_in = 1'b1; tick(1);
    rreg(2'd3, 8'h3C, "R7 line2 edge ignored as output");
    wreg(2'd3, 8'h34);
    chk("R10 manual low", cb2_out, 1'b0);
    wreg(2'd3, 8'h3C);
    wreg(2'd3, 8'h2C);
    chk("R11 strobe mode keeps level", cb2_out, 1'b1);
    wreg(2'd2, 8'h55);
    chk("R11 B write drives low", cb2_out, 1'b0);
    tick(1);
    chk("R11 B self-restores high", cb2_out, 1'b1);
    wreg(2'd1, 8'h3F);
    chk("R10 manual high A", ca2_out, 1'b1);
    ca1 = 1'b0; tick(1);
    wreg(2'd1, 8'h27);
    rreg(2'd0, 8'hAC, "R12 strobe read");
    chk("R12 A driven low", ca2_out, 1'b0);
    tick(3);
    chk("R12 A still low", ca2_out, 1'b0);
    ca1 = 1'b1; tick(1);
    chk("R12 line1 edge restores", ca2_out, 1'b1);
    wreg(2'd1, 8'h2F);
    rreg(2'd0, 8'hAC, "R11 A strobe read");
    chk("R11 A driven low", ca2_out, 1'b0);
    tick(1);
    chk("R11 A self-restores high", ca2_out, 1'b1);
    tick(2);
    chk("scoreboard drained", 8'(exp_q.size()), 8'h00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule